// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Sequencer

This block turns single-beat read and write requests from an internal requester into cycles on a multiplexed external SRAM bus. The low address byte and the data byte share one 8-bit bus. An address-latch strobe (`ale`) marks the address phase so an external latch can capture the low byte. The high address byte has its own port and holds its value for the whole cycle. Reads and writes use separate active-low strobes.

An 8-bit control register enables the bus and takes pin ownership (`bus_own`). It also splits the external space into a lower and an upper region at a programmable boundary. Each region has its own 2-bit wait code. When the region field is zero, the whole space is one region and uses the upper code.

Requests arrive on a valid/ready stream. A request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low while the bus is disabled and on every cycle of an access except its last one. A requester that holds `req_valid` with stable fields is therefore stalled through the wait states. Read data comes back as a one-cycle `rsp_valid` pulse with no back-pressure, so the requester must take it. Because `req_ready` is raised in the last cycle of an access, a waiting request gets its address phase in the very next cycle. With no pending request, `ale` stays low.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset the control register reads 0, `req_ready`, `ale`, `ad_oe`, `rsp_valid` and `bus_own` are 0, and `rd_n`, `wr_n` are 1.
- R2: A control write stores `cfg_wdata` and `cfg_rdata` returns it on the following cycle. Field layout: bit 7 enable, bits 6:4 region limit, bits 3:2 upper wait code, bits 1:0 lower wait code. `bus_own` equals bit 7.
- R3: While the enable bit is 0, `req_ready` is 0 and no access starts, whatever `req_valid` does.
- R4: The first cycle of an access is the address phase. In it `ale`=1, `ad_oe`=1 and `ad_out` is the request address bits 7:0. `ahi_out` takes address bits 15:8 in that cycle and holds them until the next access starts. `ale` is never high together with a strobe.
- R5: After the address phase the strobe (`rd_n` for a read, `wr_n` for a write) is low for 1+W consecutive cycles. W is 0, 1, 2 or 2 for wait codes 00, 01, 10 and 11. The two strobes are never low together.
- R6: Wait code 11 adds one idle cycle after the strobe, with all strobes inactive, before the next address phase.
- R7: With region limit L≠0, addresses whose bits 15:13 are ≥ L use the upper wait code and all others use the lower code. With L=0, every address uses the upper code. The code is taken when the request is accepted.
- R8: During a read strobe `ad_oe`=0. `ad_in` is sampled at the clock edge on which `rd_n` returns high. On the next cycle `rsp_valid`=1 for one cycle with that byte on `rsp_data`.
- R9: During a write strobe `ad_oe`=1 and `ad_out`=write data. A write never raises `rsp_valid`.
- R10: `req_ready` is 1 in the last strobe cycle (or in the idle cycle of R6), so a pending request gets its address phase on the next cycle. Without a request, `ale` stays 0.
- R11: `req_ready` is 0 in all other cycles of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | External byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_data | output | 8 | Read data |
| bus_own | output | 1 | Bus pins take their bus function (overrides pin direction) |
| ad_out | output | 8 | Shared address/data bus, driven value |
| ad_in | input | 8 | Shared address/data bus, sampled value |
| ad_oe | output | 1 | Output enable for the shared bus |
| ahi_out | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench uses the default parameters: a 16-bit address, an 8-bit data byte and a 3-bit region field. This makes every region boundary at a multiple of 0x2000 reachable. The bench runs accesses on both sides of the boundaries for limits 1 and 3, and also with the limit at zero. Between them these settings cover all four wait codes, the idle cycle that follows code 11, and chained requests that hit the last-cycle ready.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  localparam int LIM_W  = 3;
  localparam int CODE_W = 2;
  localparam int CNT_W  = 2;

  typedef struct packed {
    logic              en;
    logic [LIM_W-1:0]  lim;
    logic [CODE_W-1:0] wup;
    logic [CODE_W-1:0] wlo;
  } cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_RCVR = 2'd3
  } phase_e;

  // extra strobe cycles for a wait code
  function automatic logic [CNT_W-1:0] strobe_extra(input logic [CODE_W-1:0] code);
    case (code)
      2'b00:   strobe_extra = 2'd0;
      2'b01:   strobe_extra = 2'd1;
      default: strobe_extra = 2'd2;
    endcase
  endfunction

  function automatic logic needs_gap(input logic [CODE_W-1:0] code);
    needs_gap = (code == 2'b11);
  endfunction
endpackage

// File: rtl/xmb_cfg_reg.sv
module xmb_cfg_reg
  import xmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output cfg_t       cfg_o,
  output logic [7:0] rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_t'(wdata_i);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = cfg_q;
endmodule

// File: rtl/xmb_sector_dec.sv
module xmb_sector_dec
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LIM_W-1:0]  lim_i,
  input  logic [CODE_W-1:0] wup_i,
  input  logic [CODE_W-1:0] wlo_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int TOP_LSB = ADDR_W - LIM_W;

  logic [LIM_W-1:0] region;
  logic [TOP_LSB-1:0] unused_low;
  logic             upper;

  assign region     = addr_i[ADDR_W-1:TOP_LSB];
  assign unused_low = addr_i[TOP_LSB-1:0];
  assign upper      = (lim_i == '0) || (region >= lim_i);
  assign code_o     = upper ? wup_i : wlo_i;
endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [DATA_W-1:0] ad_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] ahi_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  phase_e            ph;
  logic [CNT_W-1:0]  cnt;
  logic              gap_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic              last_strb;
  logic              accept;

  assign last_strb   = (ph == PH_STRB) && (cnt == '0);
  assign req_ready_o = en_i && ((ph == PH_IDLE) || (ph == PH_RCVR) || (last_strb && !gap_q));
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      cnt         <= '0;
      gap_q       <= 1'b0;
      we_q        <= 1'b0;
      addr_q      <= '0;
      wd_q        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (ph == PH_STRB) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else if (!we_q) begin
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= ad_i;
        end
      end
      if (accept) begin
        ph     <= PH_ADDR;
        cnt    <= strobe_extra(code_i);
        gap_q  <= needs_gap(code_i);
        we_q   <= req_we_i;
        addr_q <= req_addr_i;
        wd_q   <= req_wdata_i;
      end else begin
        case (ph)
          PH_ADDR: ph <= PH_STRB;
          PH_STRB: if (cnt == '0) ph <= gap_q ? PH_RCVR : PH_IDLE;
          PH_RCVR: ph <= PH_IDLE;
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  assign ale_o   = (ph == PH_ADDR);
  assign ad_oe_o = (ph == PH_ADDR) || ((ph == PH_STRB) && we_q);
  assign ad_o    = (ph == PH_STRB) ? wd_q : addr_q[DATA_W-1:0];
  assign ahi_o   = addr_q[ADDR_W-1:DATA_W];
  assign rd_n_o  = !((ph == PH_STRB) && !we_q);
  assign wr_n_o  = !((ph == PH_STRB) && we_q);
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_own,
  output logic [DATA_W-1:0] ad_out,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] ahi_out,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  cfg_t              cfg;
  logic [CODE_W-1:0] code;

  xmb_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata)
  );

  xmb_sector_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (req_addr),
    .lim_i  (cfg.lim),
    .wup_i  (cfg.wup),
    .wlo_i  (cfg.wlo),
    .code_o (code)
  );

  xmb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (cfg.en),
    .code_i      (code),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_we_i    (req_we),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data),
    .ad_o        (ad_out),
    .ad_i        (ad_in),
    .ad_oe_o     (ad_oe),
    .ahi_o       (ahi_out),
    .ale_o       (ale),
    .rd_n_o      (rd_n),
    .wr_n_o      (wr_n)
  );

  assign bus_own = cfg.en;
endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk #(
  parameter int AHI_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             bus_own,
  input logic             ad_oe,
  input logic [AHI_W-1:0] ahi_out,
  input logic             ale,
  input logic             rd_n,
  input logic             wr_n
);
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R5
  AST_ALE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n)); // R4
  AST_ALE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R4
  AST_AHI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $stable(ahi_out)); // R4
  AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R8
  AST_RSP_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(rd_n) == 1'b0 && rd_n)); // R8
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe); // R9
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> !req_ready); // R3
endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.AHI_W(ADDR_W-DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_own   (bus_own),
  .ad_oe     (ad_oe),
  .ahi_out   (ahi_out),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n)
);

// File: tb/xmem_bus_ctrl_bench.sv
module xmem_bus_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        bus_own;
  logic [7:0]  ad_out;
  logic [7:0]  ad_in = 8'h00;
  logic        ad_oe;
  logic [7:0]  ahi_out;
  logic        ale, rd_n, wr_n;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  xmem_bus_ctrl u_xmem_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_own(bus_own),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ahi_out(ahi_out), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  // expected pin state for one cycle; ph: 0 idle, 1 address, 2 strobe, 3 gap
  typedef struct packed {
    logic [1:0] ph;
    logic       ale;
    logic       oe;
    logic [7:0] dout;
    logic       rdn;
    logic       wrn;
    logic       lastrd;
    logic       we;
  } ent_t;

  localparam ent_t IDLE_E = '{ph: 2'd0, ale: 1'b0, oe: 1'b0, dout: 8'h00,
                              rdn: 1'b1, wrn: 1'b1, lastrd: 1'b0, we: 1'b0};

  ent_t       q[$];
  logic [7:0] m_cfg = '0, m_ahi = '0, m_rdata = '0;
  logic       m_rsp = 1'b0;

  function automatic int extra_for(input int code);
    if (code == 0) return 0;
    if (code == 1) return 1;
    return 2;
  endfunction

  function automatic bit m_ready();
    return m_cfg[7] && (q.size() <= 1);
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_cfg = '0; m_ahi = '0; m_rsp = 0; m_rdata = '0;
    end else begin
      bit   acc;
      ent_t cur;
      acc = req_valid && m_ready();
      cur = (q.size() > 0) ? q[0] : IDLE_E;
      m_rsp = cur.lastrd;
      if (cur.lastrd) m_rdata = ad_in;
      if (q.size() > 0) void'(q.pop_front());
      if (acc) begin
        int lim, code, w;
        ent_t e;
        lim  = int'(m_cfg[6:4]);
        code = (lim == 0 || int'(req_addr) >= lim * 8192) ? int'(m_cfg[3:2]) : int'(m_cfg[1:0]);
        w    = extra_for(code);
        m_ahi = req_addr[15:8];
        e = IDLE_E; e.ph = 2'd1; e.ale = 1; e.oe = 1; e.dout = req_addr[7:0];
        q.push_back(e);
        for (int i = 0; i <= w; i++) begin
          e = IDLE_E; e.ph = 2'd2; e.we = req_we; e.oe = req_we;
          e.dout = req_we ? req_wdata : 8'h00;
          e.rdn = req_we; e.wrn = !req_we;
          e.lastrd = (i == w) && !req_we;
          q.push_back(e);
        end
        if (code == 3) begin
          e = IDLE_E; e.ph = 2'd3; q.push_back(e);
        end
      end
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string pin_tag(input ent_t e);
    case (e.ph)
      2'd1:    return "R4";
      2'd2:    return "R5/R7";
      2'd3:    return "R6";
      default: return "R10";
    endcase
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    ad_in <= 8'(cyc * 37 + 11);
    if (rst_n) begin
      ent_t  e;
      string t;
      e = (q.size() > 0) ? q[0] : IDLE_E;
      t = pin_tag(e);
      chk(req_ready == m_ready(), "R3/R10/R11", "req_ready", 16'(req_ready), 16'(m_ready()));
      chk(ale == e.ale, t, "ale", 16'(ale), 16'(e.ale));
      chk(rd_n == e.rdn && wr_n == e.wrn, t, "rd_n,wr_n", {14'd0, rd_n, wr_n}, {14'd0, e.rdn, e.wrn});
      chk(ad_oe == e.oe, (e.ph == 2'd2) ? (e.we ? "R9" : "R8") : t, "ad_oe", 16'(ad_oe), 16'(e.oe));
      if (e.oe) chk(ad_out == e.dout, (e.ph == 2'd2) ? "R9" : "R4", "ad_out", 16'(ad_out), 16'(e.dout));
      chk(ahi_out == m_ahi, "R4", "ahi_out", 16'(ahi_out), 16'(m_ahi));
      chk(rsp_valid == m_rsp, "R8/R9", "rsp_valid", 16'(rsp_valid), 16'(m_rsp));
      if (m_rsp) chk(rsp_data == m_rdata, "R8", "rsp_data", 16'(rsp_data), 16'(m_rdata));
      chk(cfg_rdata == m_cfg && bus_own == m_cfg[7], "R2", "cfg_rdata", 16'(cfg_rdata), 16'(m_cfg));
    end
  end

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic issue(input logic we, input logic [15:0] a, input logic [7:0] d);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    forever begin
      logic ok;
      ok = req_ready;
      @(negedge clk);
      if (ok) break;
    end
  endtask

  task automatic gap(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(cfg_rdata == 8'h00 && !req_ready && !ale && !ad_oe && !rsp_valid && !bus_own && rd_n && wr_n,
        "R1", "reset state", {cfg_rdata, 2'b0, req_ready, ale, ad_oe, rsp_valid, rd_n, wr_n},
        16'h0003);
    // R3: request offered while disabled
    req_valid = 1; req_addr = 16'h1234;
    repeat (5) @(negedge clk);
    chk(!req_ready && ale == 0, "R3", "no start while off", 16'(req_ready), 16'h0);
    gap(1);
    // R7 limit 0: all addresses take upper code 01
    wr_cfg(8'h87);
    issue(0, 16'h1234, 8'h00); gap(5);
    issue(1, 16'h0042, 8'h3C); gap(5);
    // R7 limit 3: lower code 11 (R6 gap), upper code 10
    wr_cfg(8'hBB);
    issue(0, 16'h5FFF, 8'h00); gap(7);
    issue(0, 16'h6000, 8'h00); gap(6);
    issue(1, 16'hFFFF, 8'hA5); gap(6);
    // R10: chained requests across regions
    issue(1, 16'h1000, 8'h11);
    issue(0, 16'h7000, 8'h00);
    issue(1, 16'h2001, 8'h22);
    gap(8);
    // limit 1: lower code 01, upper code 00
    wr_cfg(8'h91);
    issue(0, 16'h1FFF, 8'h00); gap(4);
    issue(0, 16'h2000, 8'h00);
    issue(1, 16'h3000, 8'h5A);
    issue(1, 16'h0100, 8'hC3);
    issue(0, 16'hE0F0, 8'h00);
    gap(6);
    // R3 again after disabling
    wr_cfg(8'h0F);
    req_valid = 1; req_addr = 16'h4444;
    repeat (4) @(negedge clk);
    gap(3);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule